// File: doc/BRIEF.md
# Modulation Strategy Selector

This block makes the final choice for one three-level stage of a cascaded-bridge space-vector modulator. Three candidate modulation results arrive together with the reference vector. Each candidate carries alpha and beta output vector components whose duties were already limited to one. Each also has a flag that says whether any duty had to be limited, and the predicted next-period DC-link voltages of the three cells it would use. The duty and trigonometry arithmetic happens upstream. Every input is signed fixed point.

The selector uses one of two cost functions. If every candidate was limited, none of them can reach the reference, so it picks the one whose output vector lies closest to the reference. If at least one candidate reached the reference without limiting, only those candidates are considered, and the one that leaves the three cells with the least predicted voltage spread wins. The result is registered one cycle after the input strobe. It gives the winning index, its output vector, the residual reference that the next stage must still produce, and a flag telling the controller that no further stage is needed.

Top module: `mod_strategy_sel`

## Requirements
- R1: While rst_ni is low, valid_o, idx_o, out_a_o, out_b_o, resid_a_o, resid_b_o and done_o are all zero.
- R2: valid_o is high exactly in the cycle after a cycle with valid_i high. When valid_i is low, all other outputs keep their values.
- R3: When all bits of cand_lim_i are 1, the chosen candidate minimises (ref_a - out_a)^2 + (ref_b - out_b)^2.
- R4: When at least one bit of cand_lim_i is 0, the chosen candidate has its cand_lim_i bit at 0. A limited candidate is never chosen, even when its imbalance is lower.
- R5: Imbalance is the sum of the squared deviations of a candidate's three predicted cell voltages from their mean. Among unlimited candidates, the one with the smallest imbalance is chosen.
- R6: When costs are equal, the candidate with the lower index wins.
- R7: out_a_o and out_b_o equal the chosen candidate's components. Candidate c occupies bits [c*VW +: VW] of cand_a_i and cand_b_i.
- R8: resid_a_o = ref_a_i - out_a_o and resid_b_o = ref_b_i - out_b_o, both computed at VW+1 bits so that they never wrap.
- R9: done_o is 1 exactly when the chosen candidate was not limited, which is the case whenever any cand_lim_i bit is 0.
- R10: idx_o is the binary candidate number, 0 to NC-1. Cell k of candidate c occupies bits [(c*NCELL+k)*DW +: DW] of cand_vdc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input set is valid |
| ref_a_i | input | VW | Reference alpha component |
| ref_b_i | input | VW | Reference beta component |
| cand_a_i | input | NC*VW | Candidate output alpha components |
| cand_b_i | input | NC*VW | Candidate output beta components |
| cand_lim_i | input | NC | Candidate needed duty limiting |
| cand_vdc_i | input | NC*NCELL*DW | Predicted cell voltages per candidate |
| valid_o | output | 1 | Result valid |
| idx_o | output | $clog2(NC) | Chosen candidate |
| out_a_o | output | VW | Chosen output alpha |
| out_b_o | output | VW | Chosen output beta |
| resid_a_o | output | VW+1 | Residual reference alpha for next stage |
| resid_b_o | output | VW+1 | Residual reference beta for next stage |
| done_o | output | 1 | No further stage needed |

## Verification
The bench sweeps all eight patterns of the limit flags. For each pattern it uses candidate values drawn from narrow ranges, so that equal costs occur often. This exposes a picker that prefers the higher index on a tie, or that lets a limited candidate with lower imbalance win when it should be excluded. A design that reversed the rule for switching between the two cost functions would pick by the wrong metric under mixed flag patterns. Extreme reference and output values check the residual. A residual computed at VW bits would wrap its sign there. Idle cycles with changed inputs check that the outputs hold their values, which catches a register that loads without the strobe.

// File: rtl/msel_pkg.sv
package msel_pkg;
  typedef enum logic {COST_ERR = 1'b0, COST_IMB = 1'b1} cost_kind_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/msel_err_cost.sv
module msel_err_cost #(
  parameter int VW = 12,
  localparam int EW = 2*VW + 2
) (
  input  logic [VW-1:0] ref_a_i,
  input  logic [VW-1:0] ref_b_i,
  input  logic [VW-1:0] out_a_i,
  input  logic [VW-1:0] out_b_i,
  output logic [EW-1:0] cost_o
);
  logic signed [VW:0]   da, db;
  logic signed [EW-1:0] dax, dbx;

  always_comb begin
    da  = $signed({ref_a_i[VW-1], ref_a_i}) - $signed({out_a_i[VW-1], out_a_i});
    db  = $signed({ref_b_i[VW-1], ref_b_i}) - $signed({out_b_i[VW-1], out_b_i});
    dax = $signed({{(EW-VW-1){da[VW]}}, da});
    dbx = $signed({{(EW-VW-1){db[VW]}}, db});
    cost_o = $unsigned(dax*dax + dbx*dbx);
  end
endmodule

// File: rtl/msel_imb_cost.sv
module msel_imb_cost #(
  parameter int DW    = 12,
  parameter int NCELL = 3,
  localparam int IMW  = 2*DW + 2*$clog2(NCELL) + 2
) (
  input  logic [NCELL*DW-1:0] vdc_i,
  output logic [IMW-1:0]      cost_o
);
  // NCELL * sum(v^2) - (sum v)^2 == NCELL * sum((v - mean)^2): no divide
  logic signed [IMW:0] vx, sum_v, sum_sq, tot;
  localparam logic signed [IMW:0] NC_S = (IMW+1)'(NCELL);

  always_comb begin
    vx     = '0;
    sum_v  = '0;
    sum_sq = '0;
    for (int k = 0; k < NCELL; k++) begin
      vx     = $signed({{(IMW+1-DW){vdc_i[k*DW+DW-1]}}, vdc_i[k*DW +: DW]});
      sum_v  = sum_v + vx;
      sum_sq = sum_sq + vx*vx;
    end
    tot    = NC_S*sum_sq - sum_v*sum_v;
    cost_o = tot[IMW-1:0];
  end
endmodule

// File: rtl/msel_pick.sv
module msel_pick #(
  parameter int NC = 3,
  parameter int CW = 32,
  localparam int IW = $clog2(NC)
) (
  input  logic [NC*CW-1:0] cost_i,
  input  logic [NC-1:0]    elig_i,
  output logic [IW-1:0]    idx_o
);
  logic [CW-1:0] best_c;
  logic          have;

  // strict less-than keeps the lower index on ties
  always_comb begin
    best_c = '0;
    idx_o  = '0;
    have   = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (elig_i[i] && (!have || (cost_i[i*CW +: CW] < best_c))) begin
        best_c = cost_i[i*CW +: CW];
        idx_o  = IW'(i);
        have   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mod_strategy_sel.sv
module mod_strategy_sel
  import msel_pkg::*;
#(
  parameter int VW    = 12,
  parameter int DW    = 12,
  parameter int NC    = 3,
  parameter int NCELL = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [VW-1:0]          ref_a_i,
  input  logic [VW-1:0]          ref_b_i,
  input  logic [NC*VW-1:0]       cand_a_i,
  input  logic [NC*VW-1:0]       cand_b_i,
  input  logic [NC-1:0]          cand_lim_i,
  input  logic [NC*NCELL*DW-1:0] cand_vdc_i,
  output logic                   valid_o,
  output logic [$clog2(NC)-1:0]  idx_o,
  output logic [VW-1:0]          out_a_o,
  output logic [VW-1:0]          out_b_o,
  output logic [VW:0]            resid_a_o,
  output logic [VW:0]            resid_b_o,
  output logic                   done_o
);
  localparam int IW  = $clog2(NC);
  localparam int EW  = 2*VW + 2;
  localparam int IMW = 2*DW + 2*$clog2(NCELL) + 2;
  localparam int CW  = max_int(EW, IMW);

  logic [NC*CW-1:0] err_cost, imb_cost, sel_cost;
  logic [NC-1:0]    elig;
  logic [IW-1:0]    pick_idx;
  logic             any_free;
  cost_kind_e       kind;
  logic [VW-1:0]    sel_a, sel_b;
  logic [VW:0]      res_a, res_b;

  for (genvar c = 0; c < NC; c++) begin : g_cand
    logic [EW-1:0]  e_c;
    logic [IMW-1:0] m_c;

    msel_err_cost #(.VW(VW)) u_err (
      .ref_a_i(ref_a_i),
      .ref_b_i(ref_b_i),
      .out_a_i(cand_a_i[c*VW +: VW]),
      .out_b_i(cand_b_i[c*VW +: VW]),
      .cost_o (e_c)
    );

    msel_imb_cost #(.DW(DW), .NCELL(NCELL)) u_imb (
      .vdc_i (cand_vdc_i[c*NCELL*DW +: NCELL*DW]),
      .cost_o(m_c)
    );

    assign err_cost[c*CW +: CW] = CW'(e_c);
    assign imb_cost[c*CW +: CW] = CW'(m_c);
  end

  assign any_free = |(~cand_lim_i);
  assign kind     = any_free ? COST_IMB : COST_ERR;
  assign sel_cost = (kind == COST_IMB) ? imb_cost : err_cost;
  assign elig     = (kind == COST_IMB) ? ~cand_lim_i : {NC{1'b1}};

  msel_pick #(.NC(NC), .CW(CW)) u_pick (
    .cost_i(sel_cost),
    .elig_i(elig),
    .idx_o (pick_idx)
  );

  assign sel_a = cand_a_i[pick_idx*VW +: VW];
  assign sel_b = cand_b_i[pick_idx*VW +: VW];
  assign res_a = {ref_a_i[VW-1], ref_a_i} - {sel_a[VW-1], sel_a};
  assign res_b = {ref_b_i[VW-1], ref_b_i} - {sel_b[VW-1], sel_b};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      idx_o     <= '0;
      out_a_o   <= '0;
      out_b_o   <= '0;
      resid_a_o <= '0;
      resid_b_o <= '0;
      done_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        idx_o     <= pick_idx;
        out_a_o   <= sel_a;
        out_b_o   <= sel_b;
        resid_a_o <= res_a;
        resid_b_o <= res_b;
        done_o    <= any_free;
      end
    end
  end
endmodule

// File: rtl/msel_checker.sv
module msel_checker #(
  parameter int VW    = 12,
  parameter int DW    = 12,
  parameter int NC    = 3,
  parameter int NCELL = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [VW-1:0]          ref_a_i,
  input logic [VW-1:0]          ref_b_i,
  input logic [NC*VW-1:0]       cand_a_i,
  input logic [NC*VW-1:0]       cand_b_i,
  input logic [NC-1:0]          cand_lim_i,
  input logic [NC*NCELL*DW-1:0] cand_vdc_i,
  input logic                   valid_o,
  input logic [$clog2(NC)-1:0]  idx_o,
  input logic [VW-1:0]          out_a_o,
  input logic [VW-1:0]          out_b_o,
  input logic [VW:0]            resid_a_o,
  input logic [VW:0]            resid_b_o,
  input logic                   done_o
);
  logic [VW-1:0] last_ref_a, last_ref_b;
  logic [VW:0]   exp_res_a, exp_res_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ref_a <= '0;
      last_ref_b <= '0;
    end else if (valid_i) begin
      last_ref_a <= ref_a_i;
      last_ref_b <= ref_b_i;
    end
  end

  assign exp_res_a = {last_ref_a[VW-1], last_ref_a} - {out_a_o[VW-1], out_a_o};
  assign exp_res_b = {last_ref_b[VW-1], last_ref_b} - {out_b_o[VW-1], out_b_o};

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && !done_o && idx_o == '0));

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(idx_o) && $stable(out_a_o) && $stable(resid_a_o) && $stable(done_o)));

  p_free_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (|(~cand_lim_i))) |=> ((($past(cand_lim_i) >> idx_o) & NC'(1)) == '0));

  p_out_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (out_a_o == VW'($past(cand_a_i) >> (idx_o*VW)) &&
                 out_b_o == VW'($past(cand_b_i) >> (idx_o*VW))));

  p_resid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (resid_a_o == exp_res_a && resid_b_o == exp_res_b));

  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (done_o == $past(|(~cand_lim_i))));

  p_idx_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(idx_o) < NC));
endmodule

bind mod_strategy_sel msel_checker #(.VW(VW), .DW(DW), .NC(NC), .NCELL(NCELL)) u_msel_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ref_a_i(ref_a_i), .ref_b_i(ref_b_i),
  .cand_a_i(cand_a_i), .cand_b_i(cand_b_i), .cand_lim_i(cand_lim_i), .cand_vdc_i(cand_vdc_i),
  .valid_o(valid_o), .idx_o(idx_o), .out_a_o(out_a_o), .out_b_o(out_b_o),
  .resid_a_o(resid_a_o), .resid_b_o(resid_b_o), .done_o(done_o)
);

// File: tb/mod_strategy_sel_tb_top.sv
module mod_strategy_sel_tb_top;
  localparam int VW = 12, DW = 12, NC = 3, NCELL = 3;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   valid_i = 1'b0;
  logic [VW-1:0]          ref_a_i = '0, ref_b_i = '0;
  logic [NC*VW-1:0]       cand_a_i = '0, cand_b_i = '0;
  logic [NC-1:0]          cand_lim_i = '0;
  logic [NC*NCELL*DW-1:0] cand_vdc_i = '0;
  logic                   valid_o, done_o;
  logic [$clog2(NC)-1:0]  idx_o;
  logic [VW-1:0]          out_a_o, out_b_o;
  logic [VW:0]            resid_a_o, resid_b_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  int ra, rb;
  int ca[NC], cb[NC];
  int vd[NC][NCELL];
  bit lim[NC];

  always #5 clk = ~clk;

  mod_strategy_sel #(.VW(VW), .DW(DW), .NC(NC), .NCELL(NCELL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ref_a_i(ref_a_i), .ref_b_i(ref_b_i),
    .cand_a_i(cand_a_i), .cand_b_i(cand_b_i), .cand_lim_i(cand_lim_i), .cand_vdc_i(cand_vdc_i),
    .valid_o(valid_o), .idx_o(idx_o), .out_a_o(out_a_o), .out_b_o(out_b_o),
    .resid_a_o(resid_a_o), .resid_b_o(resid_b_o), .done_o(done_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [VW:0] v, input int w);
    return (w == VW) ? int'($signed(v[VW-1:0])) : int'($signed(v));
  endfunction

  task automatic pack();
    ref_a_i = VW'(ra);
    ref_b_i = VW'(rb);
    for (int c = 0; c < NC; c++) begin
      cand_a_i[c*VW +: VW] = VW'(ca[c]);
      cand_b_i[c*VW +: VW] = VW'(cb[c]);
      cand_lim_i[c] = lim[c];
      for (int k = 0; k < NCELL; k++) cand_vdc_i[(c*NCELL+k)*DW +: DW] = DW'(vd[c][k]);
    end
  endtask

  // model: pairwise spread sum_{i<j}(vi-vj)^2 is proportional to the deviation sum
  task automatic apply_and_check();
    longint best, cost;
    int e_idx;
    bit any_free, have;
    any_free = 0;
    for (int c = 0; c < NC; c++) if (!lim[c]) any_free = 1;
    have = 0; e_idx = 0; best = 0;
    for (int c = 0; c < NC; c++) begin
      if (any_free && lim[c]) continue;
      if (any_free) begin
        cost = 0;
        for (int i = 0; i < NCELL; i++)
          for (int j = i+1; j < NCELL; j++)
            cost += longint'(vd[c][i]-vd[c][j]) * longint'(vd[c][i]-vd[c][j]);
      end else begin
        cost = longint'(ra-ca[c])*longint'(ra-ca[c]) + longint'(rb-cb[c])*longint'(rb-cb[c]);
      end
      if (!have || cost < best) begin best = cost; e_idx = c; have = 1; end
    end
    @(negedge clk);
    pack();
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R2 valid", valid_o, 1);
    chk(any_free ? "R4/R5/R6 idx" : "R3/R6 idx", idx_o, e_idx);
    chk("R10 idx range", (int'(idx_o) < NC), 1);
    chk("R7 out_a", sx({1'b0, out_a_o}, VW), ca[e_idx]);
    chk("R7 out_b", sx({1'b0, out_b_o}, VW), cb[e_idx]);
    chk("R8 resid_a", sx(resid_a_o, VW+1), ra - ca[e_idx]);
    chk("R8 resid_b", sx(resid_b_o, VW+1), rb - cb[e_idx]);
    chk("R9 done", done_o, any_free);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", valid_o, 0);
    chk("R1 idx", idx_o, 0);
    chk("R1 out", {out_a_o, out_b_o}, 0);
    chk("R1 resid", {resid_a_o, resid_b_o}, 0);
    chk("R1 done", done_o, 0);
    rst_ni = 1'b1;

    // R3 directed: all limited, candidate 2 closest
    ra = 100; rb = 50;
    ca = '{0, 90, 98}; cb = '{0, 40, 49};
    lim = '{1, 1, 1};
    vd = '{'{100,100,100}, '{100,100,100}, '{100,100,100}};
    apply_and_check();
    chk("R3 closest", idx_o, 2);

    // R4: limited candidate 0 has zero spread but must lose
    lim = '{1, 0, 0};
    vd = '{'{500,500,500}, '{500,510,490}, '{500,505,495}};
    apply_and_check();
    chk("R4 excluded", idx_o, 2);

    // R6: equal spread on 1 and 2
    vd = '{'{500,500,500}, '{400,410,390}, '{600,590,610}};
    apply_and_check();
    chk("R6 tie low", idx_o, 1);

    // R8 extremes: residual needs VW+1 bits
    ra = 2047; rb = -2048;
    ca = '{-2048, -2048, -2048}; cb = '{2047, 2047, 2047};
    lim = '{1, 1, 1};
    apply_and_check();
    chk("R8 wide pos", sx(resid_a_o, VW+1), 4095);
    chk("R8 wide neg", sx(resid_b_o, VW+1), -4095);

    // near-exhaustive sweep over every limit pattern
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 60; p++) begin
        for (int c = 0; c < NC; c++) begin
          lim[c] = m[c];
          ca[c] = int'($urandom_range(0, 12)) - 6;
          cb[c] = int'($urandom_range(0, 12)) - 6;
          for (int k = 0; k < NCELL; k++) vd[c][k] = 1000 + int'($urandom_range(0, 4)) - 2;
        end
        ra = (p % 10 == 0) ? int'($urandom_range(0, 4095)) - 2048 : int'($urandom_range(0, 16)) - 8;
        rb = int'($urandom_range(0, 16)) - 8;
        apply_and_check();
      end
    end

    // R2 hold: idle cycle with changed inputs
    ra = 11; rb = 12;
    ca = '{1, 2, 3}; cb = '{4, 5, 6};
    lim = '{0, 1, 1};
    vd = '{'{900,900,900}, '{800,800,800}, '{700,700,700}};
    apply_and_check();
    @(negedge clk);
    pack();
    ref_a_i = VW'(-300);
    cand_lim_i = '1;
    cand_a_i = '1;
    @(negedge clk);
    chk("R2 no valid", valid_o, 0);
    chk("R2 hold idx", idx_o, 0);
    chk("R2 hold out", sx({1'b0, out_a_o}, VW), 1);
    chk("R2 hold resid", sx(resid_a_o, VW+1), 10);
    chk("R2 hold done", done_o, 1);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule